// File: doc/BRIEF.md
# NAND Bus Phase Encoder

This block connects a simple request/response host port to an 8-bit asynchronous NAND flash bus. No register chooses between command, address and data cycles. The host picks the bus phase through bits of the byte address it uses. Setting one address bit turns the access into a command-latch cycle. Setting another turns it into an address-latch cycle. Leaving both clear gives a plain data transfer. A further address bit, if enabled, moves the access from the primary chip enable to a secondary one, so two dies can sit behind a single primary select.

Host word and halfword transfers become consecutive byte cycles on the flash bus. Every byte cycle has a fixed strobe shape: setup, low pulse and hold lengths are parameters counted in clock cycles. The ready/busy outputs of all attached dies are combined as a wired-AND, passed through a two-flop synchroniser, and read back from a status register. A small control register holds one enable bit per primary chip select. An access to a select whose bit is clear completes without touching the flash bus.

The host raises `host_req` for one cycle while the block is idle. `host_wait` stays high while the flash cycles run. A one-cycle `host_done` pulse then returns `host_rdata`.

Top module: `nand_phase_bridge`

## Requirements
- R1: Host address bit 3 set (with bit 4 clear) raises `nand_ale` for every byte cycle of that access, and `nand_cle` stays low.
- R2: Host address bit 4 set raises `nand_cle` for every byte cycle of the access, and `nand_ale` stays low even when bit 3 is also set.
- R3: With address bits 3 and 4 both clear, the access is a data cycle and both `nand_cle` and `nand_ale` stay low.
- R4: Address bit 15 clear selects the flash window, and bits 14:13 give the primary select index. If address bit 5 is set, the access drives `nand_ce2_n` low and leaves every `nand_ce_n` line high. Otherwise only `nand_ce_n[index]` goes low. Outside an access, all enables are high.
- R5: `host_size` 0 gives one byte cycle, 1 gives two and 2 or 3 gives four. Address bits 1:0 have no effect. Writes put `host_wdata` bytes on `nand_dq_o` least significant byte first.
- R6: Each byte cycle is SETUP_CYC cycles with the strobe high, then LOW_CYC cycles with `nand_we_n` (write) or `nand_re_n` (read) low, then HOLD_CYC cycles high. The enables, CLE and ALE stay constant for the whole access, and the two strobes are never low together.
- R7: A read captures `nand_dq_i` in the last low cycle of each byte and assembles the bytes least significant first into `host_rdata`. Bytes that were not read return zero.
- R8: `host_wait` is high from the cycle after the request is accepted until the last hold cycle ends. `host_done` is then high for exactly one cycle, with `host_rdata` valid.
- R9: A register read (bit 15 set, bit 2 set) returns, in bit 0, the AND of all `nand_rdy` inputs after two synchronising flops (1 = ready). The other bits are zero.
- R10: The control register (bit 15 set, bit 2 clear) holds one enable bit per primary select, in bits 3:0. A flash access to a disabled select produces no strobe and no enable, completes with `host_done` on the next cycle, and returns zero. Writes to the status register leave the control register unchanged.
- R11: During and after reset, all enables and strobes are high, CLE, ALE, `nand_dq_oe`, `host_wait` and `host_done` are low, and the control register reads zero.
- R12: `nand_dq_oe` is high exactly during the byte cycles of a flash write access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | One-cycle access request, taken only while idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address; bits choose space, select, phase and die |
| host_size | input | 2 | Transfer size: 0 byte, 1 halfword, 2/3 word |
| host_wdata | input | 32 | Write data, little-endian byte order |
| host_wait | output | 1 | High while flash cycles of the access run |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_done |
| nand_ce_n | output | NUM_CS | Primary chip enables, active low |
| nand_ce2_n | output | 1 | Secondary chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Flash data out |
| nand_dq_oe | output | 1 | Flash data output enable |
| nand_dq_i | input | 8 | Flash data in |
| nand_rdy | input | NUM_RB | Per-die ready/busy lines, combined as wired-AND |

## Verification
The assertions assume the host raises `host_req` only while `host_wait` and `host_done` are both low. They also assume `nand_dq_i` holds steady through the low phase of each read strobe. The stimulus respects both. It issues each request at a falling edge only after the reference model shows the previous access finished. It drives the flash data for a byte from the model's byte index at falling edges, so the value stays fixed for the whole byte cycle. The ready inputs change only while no status read is pending, and they stay steady for several cycles before the read, so the synchroniser has settled.

// File: rtl/nbp_pkg.sv
package nbp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_LOW   = 3'd2,
      ST_HOLD  = 3'd3,
      ST_DONE  = 3'd4
   } seq_state_e;

   // Index of the last byte cycle for a host transfer size
   function automatic logic [1:0] last_byte_of(input logic [1:0] sz);
      case (sz)
         2'd0:    last_byte_of = 2'd0;
         2'd1:    last_byte_of = 2'd1;
         default: last_byte_of = 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/nbp_rdy_sync.sv
module nbp_rdy_sync #(
   parameter int NUM_RB = 2,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_RB-1:0] rdy_in,
   output logic              rdy_sync
);

   logic [STAGES-1:0] stage_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("nbp_rdy_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[0] <= 1'b0;
               else        stage_q[0] <= &rdy_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= 1'b0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign rdy_sync = stage_q[STAGES-1];

   // R9
   rdy_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2)) |-> (rdy_sync == &$past(rdy_in, 2)));

endmodule

// File: rtl/nbp_addr_decode.sv
module nbp_addr_decode #(
   parameter int ADDR_W  = 16,
   parameter int NUM_CS  = 4,
   parameter int CS_W    = 2,
   parameter int ALE_BIT = 3,
   parameter int CLE_BIT = 4,
   parameter int SEC_BIT = 5,
   parameter bit SEC_EN  = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              reg_hit,
   output logic              reg_status,
   output logic              cle,
   output logic              ale,
   output logic              sec,
   output logic [CS_W-1:0]   cs_idx
);

   localparam int REG_BIT  = ADDR_W - 1;
   localparam int CS_TOP   = ADDR_W - 2;
   localparam int PHASE_LIM = ADDR_W - 1 - CS_W;

   generate
      if (CLE_BIT == ALE_BIT || (SEC_EN && (SEC_BIT == ALE_BIT || SEC_BIT == CLE_BIT))) begin : g_bad_overlap
         $error("nbp_addr_decode: phase and die bits must differ");
      end
      if (ALE_BIT < 2 || CLE_BIT < 2 || ALE_BIT >= PHASE_LIM || CLE_BIT >= PHASE_LIM) begin : g_bad_phase
         $error("nbp_addr_decode: phase bits out of range");
      end
      if (SEC_EN && (SEC_BIT < 2 || SEC_BIT >= PHASE_LIM)) begin : g_bad_sec
         $error("nbp_addr_decode: die bit out of range");
      end
   endgenerate

   assign reg_hit    = addr[REG_BIT];
   assign reg_status = addr[2];
   // command wins when both phase bits are set
   assign cle        = addr[CLE_BIT];
   assign ale        = addr[ALE_BIT] & ~addr[CLE_BIT];

   generate
      if (SEC_EN) begin : g_sec
         assign sec = addr[SEC_BIT];
      end else begin : g_nosec
         assign sec = 1'b0;
      end
      if (NUM_CS > 1) begin : g_multi_cs
         assign cs_idx = addr[CS_TOP -: CS_W];
      end else begin : g_single_cs
         assign cs_idx = '0;
      end
   endgenerate

endmodule

// File: rtl/nbp_bus_seq.sv
module nbp_bus_seq
   import nbp_pkg::*;
#(
   parameter int NUM_CS    = 4,
   parameter int CS_W      = 2,
   parameter int SETUP_CYC = 1,
   parameter int LOW_CYC   = 2,
   parameter int HOLD_CYC  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_flash,
   input  logic              start_other,
   input  logic [31:0]       other_rdata,
   input  logic              wr,
   input  logic [1:0]        size,
   input  logic [31:0]       wdata,
   input  logic              cle_in,
   input  logic              ale_in,
   input  logic              sec_in,
   input  logic [CS_W-1:0]   cs_in,
   input  logic [7:0]        dq_i,
   output logic              idle,
   output logic              busy,
   output logic              done,
   output logic [31:0]       rdata,
   output logic [NUM_CS-1:0] ce_n,
   output logic              ce2_n,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   output logic [7:0]        dq_o,
   output logic              dq_oe
);

   localparam int MAX_AB = (SETUP_CYC > LOW_CYC) ? SETUP_CYC : LOW_CYC;
   localparam int MAX_C  = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
   localparam int CNT_W  = $clog2(MAX_C + 1);
   localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] LOW_LAST   = CNT_W'(LOW_CYC - 1);
   localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);

   generate
      if (SETUP_CYC < 1 || LOW_CYC < 1 || HOLD_CYC < 1) begin : g_bad_timing
         $error("nbp_bus_seq: every strobe phase needs at least one cycle");
      end
   endgenerate

   seq_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [1:0]        byte_q;
   logic [1:0]        last_q;
   logic              wr_q;
   logic              cle_q;
   logic              ale_q;
   logic              sec_q;
   logic [CS_W-1:0]   cs_q;
   logic [31:0]       wdata_q;
   logic [31:0]       rdata_q;
   logic              active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         byte_q  <= '0;
         last_q  <= '0;
         wr_q    <= 1'b0;
         cle_q   <= 1'b0;
         ale_q   <= 1'b0;
         sec_q   <= 1'b0;
         cs_q    <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_flash) begin
                  state_q <= ST_SETUP;
                  cnt_q   <= '0;
                  byte_q  <= '0;
                  last_q  <= last_byte_of(size);
                  wr_q    <= wr;
                  cle_q   <= cle_in;
                  ale_q   <= ale_in;
                  sec_q   <= sec_in;
                  cs_q    <= cs_in;
                  wdata_q <= wdata;
                  rdata_q <= '0;
               end else if (start_other) begin
                  state_q <= ST_DONE;
                  rdata_q <= other_rdata;
               end
            end
            ST_SETUP: begin
               if (cnt_q == SETUP_LAST) begin
                  cnt_q   <= '0;
                  state_q <= ST_LOW;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_LOW: begin
               if (cnt_q == LOW_LAST) begin
                  cnt_q   <= '0;
                  state_q <= ST_HOLD;
                  if (!wr_q) rdata_q[{byte_q, 3'b000} +: 8] <= dq_i;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_HOLD: begin
               if (cnt_q == HOLD_LAST) begin
                  cnt_q <= '0;
                  if (byte_q == last_q) begin
                     state_q <= ST_DONE;
                  end else begin
                     byte_q  <= byte_q + 1'b1;
                     state_q <= ST_SETUP;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign active = (state_q == ST_SETUP) || (state_q == ST_LOW) || (state_q == ST_HOLD);
   assign idle   = (state_q == ST_IDLE);
   assign busy   = active;
   assign done   = (state_q == ST_DONE);
   assign rdata  = rdata_q;
   assign cle    = active & cle_q;
   assign ale    = active & ale_q;
   assign we_n   = ~((state_q == ST_LOW) & wr_q);
   assign re_n   = ~((state_q == ST_LOW) & ~wr_q);
   assign dq_o   = wdata_q[{byte_q, 3'b000} +: 8];
   assign dq_oe  = active & wr_q;
   assign ce2_n  = ~(active & sec_q);

   generate
      for (genvar i = 0; i < NUM_CS; i++) begin : g_ce
         assign ce_n[i] = ~(active & ~sec_q & (cs_q == CS_W'(i)));
      end
   endgenerate

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/nand_phase_bridge.sv
module nand_phase_bridge #(
   parameter int ADDR_W    = 16,
   parameter int NUM_CS    = 4,
   parameter int NUM_RB    = 2,
   parameter int ALE_BIT   = 3,
   parameter int CLE_BIT   = 4,
   parameter int SEC_BIT   = 5,
   parameter bit SEC_EN    = 1'b1,
   parameter int SETUP_CYC = 1,
   parameter int LOW_CYC   = 2,
   parameter int HOLD_CYC  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [1:0]        host_size,
   input  logic [31:0]       host_wdata,
   output logic              host_wait,
   output logic              host_done,
   output logic [31:0]       host_rdata,
   output logic [NUM_CS-1:0] nand_ce_n,
   output logic              nand_ce2_n,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we_n,
   output logic              nand_re_n,
   output logic [7:0]        nand_dq_o,
   output logic              nand_dq_oe,
   input  logic [7:0]        nand_dq_i,
   input  logic [NUM_RB-1:0] nand_rdy
);

   localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

   generate
      if (NUM_CS < 1 || NUM_CS > 16 || (NUM_CS & (NUM_CS - 1)) != 0) begin : g_bad_cs
         $error("nand_phase_bridge: NUM_CS must be a power of two up to 16");
      end
      if (NUM_RB < 1) begin : g_bad_rb
         $error("nand_phase_bridge: NUM_RB must be at least 1");
      end
      if (ADDR_W < 8 + CS_W || ADDR_W > 32) begin : g_bad_addr
         $error("nand_phase_bridge: ADDR_W out of range");
      end
   endgenerate

   logic              reg_hit, reg_status, dec_cle, dec_ale, dec_sec;
   logic [CS_W-1:0]   dec_cs;
   logic              seq_idle;
   logic              rdy_s;
   logic [NUM_CS-1:0] nand_en_q;
   logic              accept, start_flash, start_other;
   logic [31:0]       reg_rdata, other_rdata;

   nbp_addr_decode #(
      .ADDR_W (ADDR_W), .NUM_CS (NUM_CS), .CS_W (CS_W),
      .ALE_BIT(ALE_BIT), .CLE_BIT(CLE_BIT), .SEC_BIT(SEC_BIT), .SEC_EN(SEC_EN)
   ) u_dec (
      .addr      (host_addr),
      .reg_hit   (reg_hit),
      .reg_status(reg_status),
      .cle       (dec_cle),
      .ale       (dec_ale),
      .sec       (dec_sec),
      .cs_idx    (dec_cs)
   );

   nbp_rdy_sync #(.NUM_RB(NUM_RB), .STAGES(2)) u_rdy (
      .clk     (clk),
      .rst_n   (rst_n),
      .rdy_in  (nand_rdy),
      .rdy_sync(rdy_s)
   );

   assign accept      = host_req & seq_idle;
   assign start_flash = accept & ~reg_hit & nand_en_q[dec_cs];
   assign start_other = accept & ~start_flash;
   assign reg_rdata   = reg_status ? {31'b0, rdy_s} : {{(32-NUM_CS){1'b0}}, nand_en_q};
   assign other_rdata = reg_hit ? reg_rdata : 32'b0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nand_en_q <= '0;
      end else if (accept & reg_hit & host_wr & ~reg_status) begin
         nand_en_q <= host_wdata[NUM_CS-1:0];
      end
   end

   nbp_bus_seq #(
      .NUM_CS(NUM_CS), .CS_W(CS_W),
      .SETUP_CYC(SETUP_CYC), .LOW_CYC(LOW_CYC), .HOLD_CYC(HOLD_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_flash(start_flash),
      .start_other(start_other),
      .other_rdata(other_rdata),
      .wr         (host_wr),
      .size       (host_size),
      .wdata      (host_wdata),
      .cle_in     (dec_cle),
      .ale_in     (dec_ale),
      .sec_in     (dec_sec),
      .cs_in      (dec_cs),
      .dq_i       (nand_dq_i),
      .idle       (seq_idle),
      .busy       (host_wait),
      .done       (host_done),
      .rdata      (host_rdata),
      .ce_n       (nand_ce_n),
      .ce2_n      (nand_ce2_n),
      .cle        (nand_cle),
      .ale        (nand_ale),
      .we_n       (nand_we_n),
      .re_n       (nand_re_n),
      .dq_o       (nand_dq_o),
      .dq_oe      (nand_dq_oe)
   );

   // R2
   cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));

   // R6
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

   // R4
   ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~{nand_ce2_n, nand_ce_n}));

   // R6
   phase_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wait && $past(host_wait)) |-> $stable({nand_ce_n, nand_ce2_n, nand_cle, nand_ale}));

   // R8
   wait_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wait && host_done));

   // R10
   strobe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |-> !(&{nand_ce2_n, nand_ce_n}));

   // R10
   disabled_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_other |=> (host_done && !host_wait));

endmodule

// File: tb/tb_nand_phase_bridge.sv
module tb_nand_phase_bridge;

   localparam int ADDR_W = 16;
   localparam int NUM_CS = 4;
   localparam int NUM_RB = 2;
   localparam int S = 1;
   localparam int L = 2;
   localparam int H = 1;
   localparam int P = S + L + H;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_req = 1'b0;
   logic              host_wr = 1'b0;
   logic [ADDR_W-1:0] host_addr = '0;
   logic [1:0]        host_size = '0;
   logic [31:0]       host_wdata = '0;
   logic              host_wait, host_done;
   logic [31:0]       host_rdata;
   logic [NUM_CS-1:0] nand_ce_n;
   logic              nand_ce2_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]        nand_dq_o;
   logic [7:0]        nand_dq_i = '0;
   logic [NUM_RB-1:0] nand_rdy = '1;

   always #10 clk = ~clk;

   nand_phase_bridge #(
      .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .NUM_RB(NUM_RB),
      .SETUP_CYC(S), .LOW_CYC(L), .HOLD_CYC(H)
   ) dut (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
      .host_wait(host_wait), .host_done(host_done), .host_rdata(host_rdata),
      .nand_ce_n(nand_ce_n), .nand_ce2_n(nand_ce2_n), .nand_cle(nand_cle),
      .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
      .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
      .nand_rdy(nand_rdy)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // reference model state
   bit                m_busy = 0, m_done = 0, m_wr = 0, m_cle = 0, m_ale = 0, m_sec = 0, m_chk = 0;
   int                m_t = 0, m_n = 0, m_cs = 0;
   logic [31:0]       m_wdata = '0, m_exp = '0;
   logic [NUM_CS-1:0] m_ctrl = '0;
   logic [7:0]        m_seed = '0, seed = '0;
   string             tag = "R11";

   function automatic logic [7:0] pat(input logic [7:0] sd, input int k);
      logic [7:0] kk;
      kk = 8'(k);
      return sd ^ (8'h5A + kk * 8'd37);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_t = 0; m_ctrl = '0;
      end else if (m_busy) begin
         m_t++;
         if (m_t == m_n * P) begin m_busy = 0; m_done = 1; end
      end else if (m_done) begin
         m_done = 0;
      end else if (host_req) begin
         m_wr = host_wr;
         m_chk = !host_wr;
         if (host_addr[15]) begin
            m_exp = host_addr[2] ? {31'b0, &nand_rdy} : {28'b0, m_ctrl};
            if (host_wr && !host_addr[2]) m_ctrl = host_wdata[3:0];
            m_done = 1;
         end else begin
            m_cs = int'(host_addr[14:13]);
            if (!m_ctrl[m_cs]) begin
               m_exp = 32'b0;
               m_done = 1;
            end else begin
               m_busy = 1; m_t = 0;
               m_n = (host_size == 2'd0) ? 1 : (host_size == 2'd1) ? 2 : 4;
               m_cle = host_addr[4];
               m_ale = host_addr[3] && !host_addr[4];
               m_sec = host_addr[5];
               m_wdata = host_wdata;
               m_seed = seed;
               m_exp = '0;
               for (int k = 0; k < m_n; k++) m_exp[8*k +: 8] = pat(seed, k);
            end
         end
      end
   end

   // per-cycle comparison and flash data drive
   always @(negedge clk) begin
      if (rst_n) begin
         int r, k;
         bit low;
         logic [NUM_CS-1:0] e_ce;
         r = m_t % P;
         k = m_t / P;
         low = m_busy && (r >= S) && (r < S + L);
         e_ce = '1;
         if (m_busy && !m_sec) e_ce[m_cs] = 1'b0;
         chk(nand_ce_n == e_ce, "R4", {tag, " primary enables"}, 32'(nand_ce_n), 32'(e_ce));
         chk(nand_ce2_n == !(m_busy && m_sec), "R4", {tag, " secondary enable"}, 32'(nand_ce2_n), 32'(!(m_busy && m_sec)));
         chk(nand_cle == (m_busy && m_cle), "R2", {tag, " cle"}, 32'(nand_cle), 32'(m_busy && m_cle));
         chk(nand_ale == (m_busy && m_ale), "R1", {tag, " ale"}, 32'(nand_ale), 32'(m_busy && m_ale));
         chk(nand_we_n == !(low && m_wr), "R6", {tag, " write strobe"}, 32'(nand_we_n), 32'(!(low && m_wr)));
         chk(nand_re_n == !(low && !m_wr), "R6", {tag, " read strobe"}, 32'(nand_re_n), 32'(!(low && !m_wr)));
         chk(nand_dq_oe == (m_busy && m_wr), "R12", {tag, " output enable"}, 32'(nand_dq_oe), 32'(m_busy && m_wr));
         chk(host_wait == m_busy, "R8", {tag, " wait"}, 32'(host_wait), 32'(m_busy));
         chk(host_done == m_done, "R8", {tag, " done"}, 32'(host_done), 32'(m_done));
         if (low && m_wr)
            chk(nand_dq_o == m_wdata[8*k +: 8], "R5", {tag, " write byte"}, 32'(nand_dq_o), 32'(m_wdata[8*k +: 8]));
         if (m_done && m_chk)
            chk(host_rdata == m_exp, "R7", {tag, " read data"}, host_rdata, m_exp);
         nand_dq_i <= m_busy ? pat(m_seed, k) : 8'h00;
      end
   end

   function automatic logic [15:0] fa(input int cs, input bit sec, input bit cle,
                                      input bit ale, input logic [1:0] lo);
      logic [15:0] a;
      a = '0;
      a[14:13] = 2'(cs);
      a[5] = sec; a[4] = cle; a[3] = ale; a[1:0] = lo;
      return a;
   endfunction

   task automatic access(input string t, input bit wr, input logic [15:0] a,
                         input logic [1:0] sz, input logic [31:0] wd, input logic [7:0] sd);
      tag = t;
      seed = sd;
      host_req = 1'b1; host_wr = wr; host_addr = a; host_size = sz; host_wdata = wd;
      @(negedge clk);
      host_req = 1'b0;
      while (m_busy || m_done) @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R11: idle outputs under reset
      chk(nand_ce_n == '1 && nand_ce2_n, "R11", "enables in reset", {27'b0, nand_ce2_n, nand_ce_n}, 32'h1f);
      chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale, "R11", "strobes in reset",
          {28'b0, nand_we_n, nand_re_n, nand_cle, nand_ale}, 32'hc);
      chk(!nand_dq_oe && !host_wait && !host_done, "R11", "oe/wait/done in reset",
          {29'b0, nand_dq_oe, host_wait, host_done}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      access("R11 control reads zero", 0, 16'h8000, 2'd2, 0, 0);
      access("R10 disabled select read", 0, fa(0, 0, 0, 0, 0), 2'd2, 0, 8'h11);
      access("R10 enable select 0 and 2", 1, 16'h8000, 2'd2, 32'h5, 0);
      access("R10 control readback", 0, 16'h8000, 2'd2, 0, 0);
      access("R10 status write ignored", 1, 16'h8004, 2'd2, 32'hf, 0);
      access("R10 control unchanged", 0, 16'h8000, 2'd2, 0, 0);
      access("R2 command byte", 1, fa(0, 0, 1, 0, 0), 2'd0, 32'h70, 0);
      access("R1 address word cs2", 1, fa(2, 0, 0, 1, 2'b11), 2'd2, 32'hA1B2C3D4, 0);
      access("R2 both phase bits", 1, fa(2, 0, 1, 1, 0), 2'd1, 32'h0000_9080, 0);
      access("R3 R4 data half secondary", 1, fa(0, 1, 0, 0, 2'b01), 2'd1, 32'h0000_BEEF, 0);
      access("R7 read word cs2", 0, fa(2, 0, 0, 0, 0), 2'd2, 0, 8'h3C);
      access("R7 read byte", 0, fa(0, 0, 0, 0, 2'b10), 2'd0, 0, 8'hC3);
      access("R7 read half secondary", 0, fa(2, 1, 0, 0, 0), 2'd1, 0, 8'h99);
      access("R5 size three word", 1, fa(0, 0, 0, 0, 0), 2'd3, 32'h01234567, 0);
      access("R10 disabled select write", 1, fa(1, 0, 1, 0, 0), 2'd0, 32'hFF, 0);
      access("R10 enable all", 1, 16'h8000, 2'd2, 32'hF, 0);
      access("R7 read cs3", 0, fa(3, 0, 0, 0, 0), 2'd2, 0, 8'h42);
      nand_rdy = 2'b11;
      repeat (4) @(negedge clk);
      access("R9 status ready", 0, 16'h8004, 2'd2, 0, 0);
      nand_rdy = 2'b10;
      repeat (4) @(negedge clk);
      access("R9 status busy", 0, 16'h8004, 2'd2, 0, 0);
      nand_rdy = 2'b01;
      repeat (4) @(negedge clk);
      access("R9 status other die busy", 0, 16'h8004, 2'd2, 0, 0);
      nand_rdy = 2'b11;
      repeat (4) @(negedge clk);
      access("R9 status ready again", 0, 16'h8004, 2'd2, 0, 0);
      repeat (3) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule